// File: doc/BRIEF.md
# Two-Level Page Table Refill Walker

This block services a soft translation miss. On a start pulse it takes the faulting virtual address together with a user/executive flag and a write flag. It picks one of four page-table base addresses and fetches the table word that holds the entry. It then decides from the entry's two-bit access code whether the reference may go ahead.

A refused reference ends with a one-cycle fault pulse and a page-fail word. In this case the block writes nothing to memory and loads nothing into the map. An allowed reference first writes the table word back with the age bit of the used half cleared. It then loads two hardware map entries on back-to-back cycles, because one table half-word covers a pair of hardware pages. Memory is reached through a single-outstanding request/acknowledge port.

Top module: `pt_refill_walker`

## Requirements
- R1: The table address is the selected base plus the six-bit index taken from virtual address bits 16:11. The base is chosen from address bit 17 and the user flag: user+bit17=0 gives baseUserLow, user+bit17=1 gives baseUserHigh, exec+bit17=0 gives baseExecLow, exec+bit17=1 gives baseExecHigh.
- R2: Virtual address bit 10 selects the entry. When it is set, the entry is the right half (bits 17:0) of the fetched 36-bit word. When it is clear, the entry is the left half (bits 35:18). Entry bits 9:0 are the physical page-pair number.
- R3: Access code 00 (entry bits 17:16) refuses the reference. The block pulses fault with access field 0 and performs no write-back and no map load. The page-fail word is {user (bit 21), write (bit 20), access field (bits 19:18), virtual address (bits 17:0)}.
- R4: A write reference to code 01 faults with access field 1, and a write reference to code 10 faults with access field 2.
- R5: Code 11 yields a writable map entry. Codes 01 and 10 on a read yield a non-writable entry.
- R6: Before any map load, the fetched word is written back to the same address. Bit 13 of the selected half is cleared and every other bit is unchanged.
- R7: mapLoad is high for two consecutive cycles. The map entry is {valid=1 (bit 13), writable (bit 12), cacheable = entry bit 12 (bit 11), page (bits 10:0)}. The first load uses page {entry[9:0],0} with mapVpage = {va[17:10],0}. The second load uses page {entry[9:0],1} with mapVpage = {va[17:10],1}.
- R8: done pulses for one cycle, in the cycle right after the second map load, and never together with fault.
- R9: Each walk issues exactly one read. A raised memReq stays high with a stable address, write flag and write data until memAck.
- R10: A start pulse that arrives while a walk is in progress is ignored.
- R11: After reset, memReq, mapLoad, done and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| faultVa | input | 18 | Faulting virtual address |
| faultUser | input | 1 | Reference came from user mode |
| faultWrite | input | 1 | Reference was a write |
| baseUserLow | input | 20 | Table base, user low half of space |
| baseUserHigh | input | 20 | Table base, user high half |
| baseExecLow | input | 20 | Table base, exec low half |
| baseExecHigh | input | 20 | Table base, exec high half |
| memReq | output | 1 | Memory request, held until acknowledge |
| memWe | output | 1 | Request is a write |
| memAddr | output | 20 | Physical table address |
| memWdata | output | 36 | Write-back word |
| memAck | input | 1 | Memory acknowledge (read data valid) |
| memRdata | input | 36 | Read data |
| mapLoad | output | 1 | Hardware map load strobe |
| mapVpage | output | 9 | Virtual page being loaded |
| mapEntry | output | 14 | Map entry being loaded |
| done | output | 1 | Walk finished with map loaded |
| fault | output | 1 | Walk refused, page-fail word valid |
| pfWord | output | 22 | Page-fail word |

## Verification
The assertions assume that the memory side acknowledges only while a request is raised, and with a single pulse per request. The bench servant raises memAck only against a pending memReq, after a random wait of 0 to 3 cycles, and drops it on the next cycle. The assertions also assume that the base inputs do not change during a walk, and the bench holds them constant throughout. Start pulses that overlap a walk are generated on purpose, but only after the walk has captured its inputs.

// File: rtl/walk_pkg.sv
package walk_pkg;
  parameter int VA_W         = 18;
  parameter int HALF_W       = 18;
  parameter int WORD_W       = 2 * HALF_W;
  parameter int IDX_W        = 6;
  parameter int IDX_LSB      = 11;
  parameter int HALF_SEL_BIT = 10;
  parameter int HI_SEL_BIT   = VA_W - 1;
  parameter int AGE_BIT      = 13;
  parameter int CACHE_BIT    = 12;
  parameter int PPN_SRC_W    = 10;
  parameter int PPN_W        = PPN_SRC_W + 1;
  parameter int VPN_LSB      = 9;
  parameter int VPN_W        = VA_W - VPN_LSB;
  parameter int NUM_BASE     = 4;

  localparam logic [1:0] ACC_NONE = 2'b00;
  localparam logic [1:0] ACC_RO   = 2'b01;
  localparam logic [1:0] ACC_RWF  = 2'b10;
  localparam logic [1:0] ACC_RW   = 2'b11;

  typedef struct packed {
    logic             valid;
    logic             writable;
    logic             cacheable;
    logic [PPN_W-1:0] page;
  } mapEntry_t;

  typedef struct packed {
    logic            user;
    logic            write;
    logic [1:0]      access;
    logic [VA_W-1:0] va;
  } pfWord_t;

  typedef struct packed {
    logic capture;
    logic takeRead;
    logic decide;
    logic memReq;
    logic memWe;
    logic mapLoad;
    logic loadOdd;
  } walkStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_DECIDE, S_WRITE, S_LOAD_EVEN, S_LOAD_ODD, S_DONE, S_FAULT
  } walkState_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memAck,
  input  logic [1:0]  entryCode,
  input  logic        wasWrite,
  output walkStrobe_t strobe,
  output logic        done,
  output logic        fault
);
  walkState_t state, stateNext;
  logic deny;

  assign deny = (entryCode == ACC_NONE) || ((entryCode != ACC_RW) && wasWrite);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    done      = 1'b0;
    fault     = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        strobe.capture = 1'b1;
        stateNext      = S_READ;
      end
      S_READ: begin
        strobe.memReq = 1'b1;
        if (memAck) begin
          strobe.takeRead = 1'b1;
          stateNext       = S_DECIDE;
        end
      end
      S_DECIDE: begin
        strobe.decide = 1'b1;
        stateNext     = deny ? S_FAULT : S_WRITE;
      end
      S_WRITE: begin
        strobe.memReq = 1'b1;
        strobe.memWe  = 1'b1;
        if (memAck) stateNext = S_LOAD_EVEN;
      end
      S_LOAD_EVEN: begin
        strobe.mapLoad = 1'b1;
        stateNext      = S_LOAD_ODD;
      end
      S_LOAD_ODD: begin
        strobe.mapLoad = 1'b1;
        strobe.loadOdd = 1'b1;
        stateNext      = S_DONE;
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      S_FAULT: begin
        fault     = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  // R9: a pending request is held, with the same direction, until acknowledged
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memReq && !memAck |=> strobe.memReq && (strobe.memWe == $past(strobe.memWe)));

  // R8: done only follows a map load
  a_r8_done_after_load: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strobe.mapLoad) && !fault);

  // R7: the map is always loaded as a pair
  a_r7_load_pair: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.mapLoad) |=> strobe.mapLoad);

  // R3: a refusal never comes with a load or a request
  a_r3_fault_quiet: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !strobe.mapLoad && !strobe.memReq && !done);
endmodule

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
#(
  parameter int PA_W = 20
)(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   faultVa,
  input  logic              faultUser,
  input  logic              faultWrite,
  input  logic [PA_W-1:0]   baseUserLow,
  input  logic [PA_W-1:0]   baseUserHigh,
  input  logic [PA_W-1:0]   baseExecLow,
  input  logic [PA_W-1:0]   baseExecHigh,
  input  logic [WORD_W-1:0] memRdata,
  output logic [PA_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [1:0]        entryCode,
  output logic              wasWrite,
  output logic [VPN_W-1:0]  mapVpage,
  output mapEntry_t         mapEntry,
  output pfWord_t           pfWord
);
  logic [VA_W-1:0]      vaQ;
  logic                 userQ, writeQ;
  logic [PA_W-1:0]      addrQ;
  logic [WORD_W-1:0]    wordQ;
  logic                 writableQ, cacheQ;
  logic [PPN_SRC_W-1:0] ppnQ;
  pfWord_t              pfQ;

  logic [PA_W-1:0]   baseArr [NUM_BASE];
  logic [1:0]        baseIdx;
  logic [PA_W-1:0]   tableAddr;
  logic              selRight;
  logic [HALF_W-1:0] entry;
  logic [1:0]        accField;

  assign baseArr[0] = baseUserLow;
  assign baseArr[1] = baseUserHigh;
  assign baseArr[2] = baseExecLow;
  assign baseArr[3] = baseExecHigh;
  assign baseIdx    = {~faultUser, faultVa[HI_SEL_BIT]};
  assign tableAddr  = baseArr[baseIdx] + PA_W'(faultVa[IDX_LSB +: IDX_W]);

  assign selRight  = vaQ[HALF_SEL_BIT];
  assign entry     = selRight ? wordQ[HALF_W-1:0] : wordQ[WORD_W-1:HALF_W];
  assign entryCode = entry[HALF_W-1 -: 2];
  assign wasWrite  = writeQ;

  always_comb begin
    case (entryCode)
      ACC_RO:  accField = 2'd1;
      ACC_RWF: accField = 2'd2;
      default: accField = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ       <= '0;
      userQ     <= 1'b0;
      writeQ    <= 1'b0;
      addrQ     <= '0;
      wordQ     <= '0;
      writableQ <= 1'b0;
      cacheQ    <= 1'b0;
      ppnQ      <= '0;
      pfQ       <= '0;
    end else begin
      if (strobe.capture) begin
        vaQ    <= faultVa;
        userQ  <= faultUser;
        writeQ <= faultWrite;
        addrQ  <= tableAddr;
      end
      if (strobe.takeRead) wordQ <= memRdata;
      if (strobe.decide) begin
        writableQ <= (entryCode == ACC_RW);
        cacheQ    <= entry[CACHE_BIT];
        ppnQ      <= entry[PPN_SRC_W-1:0];
        pfQ       <= '{user: userQ, write: writeQ, access: accField, va: vaQ};
      end
    end
  end

  // write-back word: the age bit is cleared only in the half that was used
  localparam logic [HALF_W-1:0] AGE_MASK = HALF_W'(1) << AGE_BIT;
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic clearHere;
    assign clearHere = (h == 0) ? selRight : ~selRight;
    assign memWdata[h*HALF_W +: HALF_W] =
      wordQ[h*HALF_W +: HALF_W] & ~(clearHere ? AGE_MASK : '0);
  end

  assign memAddr  = addrQ;
  assign mapVpage = {vaQ[VA_W-1:VPN_LSB+1], strobe.loadOdd};
  assign mapEntry = '{valid: 1'b1, writable: writableQ, cacheable: cacheQ,
                      page: {ppnQ, strobe.loadOdd}};
  assign pfWord   = pfQ;

  // R9: address and data do not move while a request stays up
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memReq && $past(strobe.memReq) |-> $stable(memAddr) && $stable(memWdata));

  // R7: even load is followed by the odd load of the same page pair
  a_r7_even_then_odd: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mapLoad && !strobe.loadOdd |=>
      strobe.loadOdd && $stable(mapVpage[VPN_W-1:1]) && $stable(mapEntry.page[PPN_W-1:1]));
endmodule

// File: rtl/pt_refill_walker.sv
module pt_refill_walker
  import walk_pkg::*;
#(
  parameter int PA_W = 20
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [17:0]       faultVa,
  input  logic              faultUser,
  input  logic              faultWrite,
  input  logic [PA_W-1:0]   baseUserLow,
  input  logic [PA_W-1:0]   baseUserHigh,
  input  logic [PA_W-1:0]   baseExecLow,
  input  logic [PA_W-1:0]   baseExecHigh,
  output logic              memReq,
  output logic              memWe,
  output logic [PA_W-1:0]   memAddr,
  output logic [35:0]       memWdata,
  input  logic              memAck,
  input  logic [35:0]       memRdata,
  output logic              mapLoad,
  output logic [8:0]        mapVpage,
  output logic [13:0]       mapEntry,
  output logic              done,
  output logic              fault,
  output logic [21:0]       pfWord
);
  walkStrobe_t strobe;
  logic [1:0]  entryCode;
  logic        wasWrite;
  mapEntry_t   entryS;
  pfWord_t     pfS;

  walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck),
    .entryCode(entryCode), .wasWrite(wasWrite),
    .strobe(strobe), .done(done), .fault(fault)
  );

  walk_dp #(.PA_W(PA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .faultVa(faultVa), .faultUser(faultUser), .faultWrite(faultWrite),
    .baseUserLow(baseUserLow), .baseUserHigh(baseUserHigh),
    .baseExecLow(baseExecLow), .baseExecHigh(baseExecHigh),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .entryCode(entryCode), .wasWrite(wasWrite),
    .mapVpage(mapVpage), .mapEntry(entryS), .pfWord(pfS)
  );

  assign memReq   = strobe.memReq;
  assign memWe    = strobe.memWe;
  assign mapLoad  = strobe.mapLoad;
  assign mapEntry = entryS;
  assign pfWord   = pfS;

  // R4: a refusal with a nonzero access field only happens on a write
  a_r4_ro_fault_is_write: assert property (@(posedge clk) disable iff (!rstN)
    fault && (pfS.access != 2'd0) |-> pfS.write);
endmodule

// File: tb/pt_refill_walker_bench.sv
module pt_refill_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 20;
  localparam logic [PA_W-1:0] B_UL = 20'hA1000, B_UH = 20'hA1040,
                              B_EL = 20'hA1080, B_EH = 20'hA10C0;

  logic clk = 0, rstN = 0, start = 0;
  logic [17:0] faultVa = '0;
  logic faultUser = 0, faultWrite = 0;
  logic memReq, memWe, memAck = 0;
  logic [PA_W-1:0] memAddr;
  logic [35:0] memWdata, memRdata = '0;
  logic mapLoad, done, fault;
  logic [8:0] mapVpage;
  logic [13:0] mapEntry;
  logic [21:0] pfWord;

  pt_refill_walker #(.PA_W(PA_W)) u_pt_refill_walker (
    .clk(clk), .rstN(rstN), .start(start), .faultVa(faultVa),
    .faultUser(faultUser), .faultWrite(faultWrite),
    .baseUserLow(B_UL), .baseUserHigh(B_UH), .baseExecLow(B_EL), .baseExecHigh(B_EH),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .mapLoad(mapLoad), .mapVpage(mapVpage),
    .mapEntry(mapEntry), .done(done), .fault(fault), .pfWord(pfWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [35:0] mem [256];

  int nReads, nWrites, nLoads, loadsAtWrite, ld1Cyc, doneCyc, dly = 0;
  logic [PA_W-1:0] rdAddr, wrAddr;
  logic [35:0] wrData;
  logic [8:0] ld0Vp, ld1Vp;
  logic [13:0] ld0En, ld1En;
  logic gotDone, gotFault;
  logic [21:0] pfGot;

  always @(posedge clk) cyc++;

  // memory servant
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (dly > 0) dly--;
      else begin
        memAck = 1'b1;
        if (memWe) begin
          mem[memAddr[7:0]] = memWdata;
          nWrites++; wrAddr = memAddr; wrData = memWdata; loadsAtWrite = nLoads;
        end else begin
          memRdata = mem[memAddr[7:0]];
          nReads++; rdAddr = memAddr;
        end
        dly = int'($urandom % 4);
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (mapLoad) begin
      if (nLoads == 0) begin ld0Vp = mapVpage; ld0En = mapEntry; end
      else if (nLoads == 1) begin ld1Vp = mapVpage; ld1En = mapEntry; ld1Cyc = cyc; end
      nLoads++;
    end
    if (done && !gotDone) begin gotDone = 1; doneCyc = cyc; end
    if (fault && !gotFault) begin gotFault = 1; pfGot = pfWord; end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] baseOf(input logic user, input logic hi);
    case ({user, hi})
      2'b10: return B_UL;
      2'b11: return B_UH;
      2'b00: return B_EL;
      default: return B_EH;
    endcase
  endfunction

  task automatic runWalk(input logic [17:0] va, input logic user, input logic wr, input bit inject);
    logic [PA_W-1:0] eAddr;
    logic [35:0] word, eWb;
    logic [17:0] half;
    logic [1:0] code, acc;
    logic eFault, eWrit;
    int n;
    eAddr = baseOf(user, va[17]) + PA_W'(va[16:11]);
    word  = mem[eAddr[7:0]];
    half  = va[10] ? word[17:0] : word[35:18];
    code  = half[17:16];
    eFault = (code == 2'b00) || (code != 2'b11 && wr);
    eWrit  = (code == 2'b11);
    acc    = (code == 2'b01) ? 2'd1 : (code == 2'b10) ? 2'd2 : 2'd0;
    eWb    = word;
    if (va[10]) eWb[13] = 1'b0; else eWb[31] = 1'b0;
    nReads = 0; nWrites = 0; nLoads = 0; loadsAtWrite = -1;
    gotDone = 0; gotFault = 0; ld1Cyc = -5; doneCyc = -1;
    @(negedge clk); faultVa = va; faultUser = user; faultWrite = wr; start = 1;
    @(negedge clk); start = 0;
    if (inject) begin
      @(negedge clk); faultVa = ~va; faultUser = ~user; faultWrite = ~wr; start = 1;
      @(negedge clk); start = 0;
    end
    n = 0;
    while (!(gotDone || gotFault) && n < 300) begin @(posedge clk); n++; end
    repeat (12) @(negedge clk);
    chk("R9 one read", 64'(nReads), 64'd1);
    chk("R1 table address", 64'(rdAddr), 64'(eAddr));
    if (eFault) begin
      chk("R3 fault pulse", {62'd0, gotFault, gotDone}, {62'd0, 2'b10});
      chk("R4 page-fail word", 64'(pfGot), 64'({user, wr, acc, va}));
      chk("R3 no write-back or load", 64'(nWrites + nLoads), 64'd0);
    end else begin
      chk("R6 write-back address", 64'(wrAddr), 64'(eAddr));
      chk("R6 write-back data", 64'(wrData), 64'(eWb));
      chk("R6 write before load", 64'(loadsAtWrite), 64'd0);
      chk("R2 entry page from selected half", 64'(ld0En[10:1]), 64'(half[9:0]));
      chk("R5 writable", {62'd0, ld0En[12], ld1En[12]}, {62'd0, eWrit, eWrit});
      chk("R7 even load", 64'({ld0Vp, ld0En}), 64'({va[17:10], 1'b0, 3'b100 | {1'b0, eWrit, half[12]}, half[9:0], 1'b0}));
      chk("R7 odd load", 64'({ld1Vp, ld1En}), 64'({va[17:10], 1'b1, 3'b100 | {1'b0, eWrit, half[12]}, half[9:0], 1'b1}));
      chk("R8 done after second load", 64'(doneCyc - ld1Cyc), 64'd1);
      chk("R8 load count and no fault", {32'(nLoads), 31'd0, gotFault}, {32'd2, 32'd0});
    end
    if (inject) chk("R10 overlapping start ignored", 64'(nReads + nWrites), eFault ? 64'd1 : 64'd2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {60'd0, memReq, mapLoad, done, fault}, 64'd0);
    rstN = 1;
    @(negedge clk);
    chk("R11 idle after reset", {60'd0, memReq, mapLoad, done, fault}, 64'd0);
    // directed: every code, both halves, read and write, all four bases
    for (int c = 0; c < 4; c++)
      for (int h = 0; h < 2; h++)
        for (int w = 0; w < 2; w++)
          for (int b = 0; b < 4; b++) begin
            logic [17:0] va;
            logic [PA_W-1:0] a;
            va = 18'($urandom);
            va[17] = b[0]; va[10] = h[0];
            a = baseOf(b[1], b[0]) + PA_W'(va[16:11]);
            if (h == 1) mem[a[7:0]][17:16] = c[1:0];
            else        mem[a[7:0]][35:34] = c[1:0];
            runWalk(va, b[1], w[0], 1'b0);
          end
    // overlapping start pulses
    for (int k = 0; k < 8; k++) runWalk(18'($urandom), 1'($urandom), 1'($urandom), 1'b1);
    // random walks
    for (int k = 0; k < 300; k++) runWalk(18'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule